// File: doc/BRIEF.md
# Byte-Lane Word Access Splitter

This block connects a 16-bit requester to a byte-addressed memory whose 16-bit data path is divided into two byte lanes. The even lane carries bits 7..0 and serves even byte addresses. The odd lane carries bits 15..8 and serves odd byte addresses. The requester presents one read or write at a time, as a single byte or as a little-endian word, at any byte address. The block drives the bus address, whose bit 0 low enables the even lane, and an active-low enable for the odd lane. It places write data on the lanes that are used and collects read data from them.

A word at an even address moves in one bus cycle. A word at an odd address is split into two byte cycles. The first cycle moves the low byte at the odd address on the odd lane. The second cycle moves the high byte at the next address on the even lane. The memory stretches any bus cycle by holding `bus_ready` low. The requester sees a single `done` pulse once the last cycle has finished, with the read result complete at that moment.

Top module: `lane_access_splitter`

## Requirements
- R1: After reset, `bus_cyc` is 0, `done` is 0 and `req_ready` is 1.
- R2: A word at an even address makes exactly one bus cycle at that address with `bus_hi_n`=0. A write drives `req_wdata` unchanged. A read returns `bus_rdata` unchanged.
- R3: A byte at an even address makes one bus cycle at that address with `bus_hi_n`=1. A write drives the byte `req_wdata[7:0]` on both lanes. A read returns {8'h00, `bus_rdata[7:0]`}.
- R4: A byte at an odd address makes one bus cycle at that address with `bus_hi_n`=0. A write drives the byte on both lanes. A read returns {8'h00, `bus_rdata[15:8]`}.
- R5: A word at an odd address A makes two bus cycles. The first is at A with `bus_hi_n`=0 and carries `req_wdata[7:0]` on both lanes. The second is at A+1 with `bus_hi_n`=1 and carries `req_wdata[15:8]` on both lanes. A read returns the first cycle's bits 15..8 as the low byte and the second cycle's bits 7..0 as the high byte.
- R6: While `bus_ready` is 0 during a bus cycle, the next clock keeps that cycle with the same address, odd-lane enable, direction and write data.
- R7: `done` is high for exactly one clock, in the clock after the edge where `bus_ready` ends the final bus cycle. For reads, `rdata` holds the complete result in that clock.
- R8: A request is taken only at an edge where `req_ready` is 1. `req_ready` is 0 while a bus cycle is in progress, and `req_valid` raised during that time leaves the bus cycles unchanged.
- R9: The second cycle of a split word at the highest byte address goes to address 0, because the address wraps modulo 2^AW.
- R10: `bus_we` equals the request direction for every bus cycle of that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and takes a request at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | AW | Byte address |
| req_wdata | input | 16 | Write data; a byte uses bits 7..0 |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Read result, valid with `done` |
| bus_cyc | output | 1 | Bus cycle in progress |
| bus_we | output | 1 | Bus cycle direction, 1 = write |
| bus_addr | output | AW | Bus byte address; bit 0 low enables the even lane |
| bus_hi_n | output | 1 | Active-low odd-lane enable |
| bus_wdata | output | 16 | Bus write data, both lanes |
| bus_rdata | input | 16 | Bus read data, both lanes |
| bus_ready | input | 1 | Ends the current bus cycle at this edge when high |

## Verification
The properties assume that the memory looks at `bus_ready` only while `bus_cyc` is high. They also assume the requester may hold `req_valid` high at any time, busy or not. The stimulus raises `bus_ready` only inside a bus cycle and adds a chosen number of wait clocks to each cycle. It deliberately raises `req_valid` with a different address in the first clock of a busy request, to show that the request is not taken. Read data comes from a byte memory model in the bench, which is updated only by accepted write cycles on their enabled lanes.

// File: rtl/lane_pkg.sv
// Shared definitions for the byte-lane access splitter.
// Assumes two byte lanes of equal width on the memory side.
package lane_pkg;
    localparam int LANE_W = 8;
    localparam int BUS_W  = 2 * LANE_W;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2
    } lane_phase_e;
endpackage

// File: rtl/lane_seq.sv
// Request sequencer: holds the accepted request and steps through one or
// two bus phases, ending each phase on bus_ready. Assumes the request
// fields are valid in the cycle req_valid is sampled while idle.
module lane_seq #(
    parameter int AW = 20
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic                         req_write,
    input  logic                         req_word,
    input  logic [AW-1:0]                req_addr,
    input  logic [lane_pkg::BUS_W-1:0]   req_wdata,
    input  logic                         bus_ready,
    output lane_pkg::lane_phase_e        phase,
    output logic                         held_write,
    output logic                         held_word,
    output logic [AW-1:0]                held_addr,
    output logic [lane_pkg::BUS_W-1:0]   held_wdata,
    output logic                         done
);
    import lane_pkg::*;

    logic split;
    // Misaligned word needs a second phase.
    always_comb split = held_word && held_addr[0];

    // Phase register, held request and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            held_write <= 1'b0;
            held_word  <= 1'b0;
            held_addr  <= '0;
            held_wdata <= '0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: if (req_valid) begin
                    held_write <= req_write;
                    held_word  <= req_word;
                    held_addr  <= req_addr;
                    held_wdata <= req_wdata;
                    phase      <= PH_FIRST;
                end
                PH_FIRST: if (bus_ready) begin
                    if (split) begin
                        phase <= PH_SECOND;
                    end else begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end
                end
                PH_SECOND: if (bus_ready) begin
                    phase <= PH_IDLE;
                    done  <= 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lane_steer.sv
// Bus driver: turns the held request and the current phase into address,
// odd-lane enable, direction and lane-steered write data. Purely
// combinational; byte cycles place their byte on both lanes.
module lane_steer #(
    parameter int AW = 20
) (
    input  lane_pkg::lane_phase_e        phase,
    input  logic                         held_write,
    input  logic                         held_word,
    input  logic [AW-1:0]                held_addr,
    input  logic [lane_pkg::BUS_W-1:0]   held_wdata,
    output logic                         bus_cyc,
    output logic                         bus_we,
    output logic [AW-1:0]                bus_addr,
    output logic                         bus_hi_n,
    output logic [lane_pkg::BUS_W-1:0]   bus_wdata
);
    import lane_pkg::*;

    localparam logic [AW-1:0] ADDR_STEP = AW'(1);

    logic [LANE_W-1:0] lo_byte, hi_byte;
    logic              odd;

    // Split the held write data and address parity.
    always_comb begin
        lo_byte = held_wdata[LANE_W-1:0];
        hi_byte = held_wdata[BUS_W-1:LANE_W];
        odd     = held_addr[0];
    end

    // Per-phase drive of the bus signals.
    always_comb begin
        bus_cyc   = (phase != PH_IDLE);
        bus_we    = held_write && bus_cyc;
        bus_addr  = held_addr;
        bus_hi_n  = 1'b1;
        bus_wdata = '0;
        case (phase)
            PH_FIRST: begin
                bus_hi_n  = !(held_word || odd);
                bus_wdata = (held_word && !odd) ? held_wdata : {lo_byte, lo_byte};
            end
            PH_SECOND: begin
                bus_addr  = held_addr + ADDR_STEP;
                bus_hi_n  = 1'b1;
                bus_wdata = {hi_byte, hi_byte};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lane_collect.sv
// Read assembler: captures lane data at each finishing edge and builds the
// result word. Assumes bus_rdata is valid whenever bus_ready ends a phase.
module lane_collect (
    input  logic                         clk,
    input  logic                         rst_n,
    input  lane_pkg::lane_phase_e        phase,
    input  logic                         held_word,
    input  logic                         held_odd,
    input  logic                         bus_ready,
    input  logic [lane_pkg::BUS_W-1:0]   bus_rdata,
    output logic [lane_pkg::BUS_W-1:0]   rdata
);
    import lane_pkg::*;

    // Capture the used lane(s) on every completed phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (bus_ready) begin
            if (phase == PH_FIRST) begin
                if (held_word && !held_odd)
                    rdata <= bus_rdata;
                else if (held_odd)
                    rdata <= {{LANE_W{1'b0}}, bus_rdata[BUS_W-1:LANE_W]};
                else
                    rdata <= {{LANE_W{1'b0}}, bus_rdata[LANE_W-1:0]};
            end else if (phase == PH_SECOND) begin
                rdata[BUS_W-1:LANE_W] <= bus_rdata[LANE_W-1:0];
            end
        end
    end
endmodule

// File: rtl/lane_access_splitter.sv
// Top level: byte/word access splitter for a two-lane byte memory.
// Aligned words use one bus cycle, misaligned words two byte cycles.
// Assumes one outstanding request; req_ready shows when one is taken.
module lane_access_splitter #(
    parameter int AW = 20
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic                         req_write,
    input  logic                         req_word,
    input  logic [AW-1:0]                req_addr,
    input  logic [lane_pkg::BUS_W-1:0]   req_wdata,
    output logic                         done,
    output logic [lane_pkg::BUS_W-1:0]   rdata,
    output logic                         bus_cyc,
    output logic                         bus_we,
    output logic [AW-1:0]                bus_addr,
    output logic                         bus_hi_n,
    output logic [lane_pkg::BUS_W-1:0]   bus_wdata,
    input  logic [lane_pkg::BUS_W-1:0]   bus_rdata,
    input  logic                         bus_ready
);
    import lane_pkg::*;

    lane_phase_e        phase;
    logic               held_write, held_word;
    logic [AW-1:0]      held_addr;
    logic [BUS_W-1:0]   held_wdata;

    // Idle means a new request is taken at the next edge.
    always_comb req_ready = (phase == PH_IDLE);

    lane_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_word(req_word),
        .req_addr(req_addr), .req_wdata(req_wdata), .bus_ready(bus_ready),
        .phase(phase), .held_write(held_write), .held_word(held_word),
        .held_addr(held_addr), .held_wdata(held_wdata), .done(done)
    );

    lane_steer #(.AW(AW)) u_steer (
        .phase(phase), .held_write(held_write), .held_word(held_word),
        .held_addr(held_addr), .held_wdata(held_wdata),
        .bus_cyc(bus_cyc), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_hi_n(bus_hi_n), .bus_wdata(bus_wdata)
    );

    lane_collect u_collect (
        .clk(clk), .rst_n(rst_n), .phase(phase),
        .held_word(held_word), .held_odd(held_addr[0]),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata), .rdata(rdata)
    );
endmodule

// File: rtl/lane_splitter_chk.sv
// Protocol checker for lane_access_splitter, attached by bind.
// Observes only the top-level ports.
module lane_splitter_chk #(
    parameter int AW = 20
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_ready,
    input logic                        done,
    input logic                        bus_cyc,
    input logic                        bus_we,
    input logic [AW-1:0]               bus_addr,
    input logic                        bus_hi_n,
    input logic [lane_pkg::BUS_W-1:0]  bus_wdata,
    input logic                        bus_ready
);
    // R6
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !bus_ready) |=> (bus_cyc && $stable(bus_addr) &&
            $stable(bus_hi_n) && $stable(bus_we) && $stable(bus_wdata)));

    // R4
    odd_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_addr[0]) |-> !bus_hi_n);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_after_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_cyc) |-> done);

    // R8
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !bus_cyc);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_ready && !bus_cyc));
endmodule

bind lane_access_splitter lane_splitter_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
    .bus_cyc(bus_cyc), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_hi_n(bus_hi_n), .bus_wdata(bus_wdata), .bus_ready(bus_ready)
);

// File: tb/test_lane_access_splitter.sv
module test_lane_access_splitter;
    localparam int AW = 20;
    localparam int AMASK = (1 << AW) - 1;

    typedef struct {
        int          a;
        logic        hn;
        logic [15:0] wd;
    } beat_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic          req_ready, done, bus_cyc, bus_we, bus_hi_n;
    logic [15:0]   rdata, bus_wdata;
    logic [AW-1:0] bus_addr;
    logic [15:0]   bus_rdata = '0;
    logic          bus_ready = 1'b0;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [7:0] mem [int];

    always #2 clk = ~clk;

    lane_access_splitter #(.AW(AW)) i_lane_access_splitter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_word(req_word), .req_addr(req_addr),
        .req_wdata(req_wdata), .done(done), .rdata(rdata), .bus_cyc(bus_cyc),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_hi_n(bus_hi_n),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] rb(input int a);
        int m = a & AMASK;
        if (mem.exists(m)) return mem[m];
        return 8'(m ^ (m >> 8) ^ 8'h5A);
    endfunction

    // Drives one request and compares the bus and result on every clock.
    task automatic run_req(input bit wr, input bit word, input int a0,
                           input logic [15:0] wd, input int waits,
                           input bit poke, input string tag);
        beat_t q[$];
        beat_t b;
        logic [15:0] exp_rd;
        int a = a0 & AMASK;
        int wl = waits;
        bit first = 1;
        if (word && (a % 2 == 0)) begin
            q.push_back('{a, 1'b0, wd});
            exp_rd = {rb(a + 1), rb(a)};
        end else if (word) begin
            q.push_back('{a, 1'b0, {wd[7:0], wd[7:0]}});
            q.push_back('{(a + 1) & AMASK, 1'b1, {wd[15:8], wd[15:8]}});
            exp_rd = {rb(a + 1), rb(a)};
        end else begin
            q.push_back('{a, (a % 2 == 0), {wd[7:0], wd[7:0]}});
            exp_rd = {8'h00, rb(a)};
        end
        @(negedge clk);
        chk(req_ready === 1'b1, "R8", "req_ready before request", 32'(req_ready), 1);
        req_valid = 1'b1; req_write = wr; req_word = word;
        req_addr = AW'(a); req_wdata = wd;
        @(posedge clk);
        while (q.size() > 0) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (first && poke) begin
                req_valid = 1'b1;
                req_addr = AW'(a ^ 32'h404);
                req_word = ~word;
                chk(req_ready === 1'b0, "R8", "req_ready while busy", 32'(req_ready), 0);
            end
            b = q[0];
            chk(bus_cyc === 1'b1, tag, "bus_cyc", 32'(bus_cyc), 1);
            chk(bus_addr === AW'(b.a), (wl != waits) ? "R6" : tag, "bus_addr", 32'(bus_addr), 32'(b.a));
            chk(bus_hi_n === b.hn, tag, "bus_hi_n", 32'(bus_hi_n), 32'(b.hn));
            chk(bus_we === wr, "R10", "bus_we", 32'(bus_we), 32'(wr));
            if (wr) chk(bus_wdata === b.wd, tag, "bus_wdata", 32'(bus_wdata), 32'(b.wd));
            bus_rdata = {rb(b.a | 1), rb(b.a & ~1)};
            if (wl > 0) begin
                bus_ready = 1'b0;
                wl--;
            end else begin
                bus_ready = 1'b1;
            end
            @(posedge clk);
            if (bus_ready) begin
                if (wr) begin
                    if (b.a % 2 == 0) mem[b.a] = b.wd[7:0];
                    if (!b.hn) mem[b.a | 1] = b.wd[15:8];
                end
                void'(q.pop_front());
                wl = waits;
            end
            first = 0;
        end
        @(negedge clk);
        bus_ready = 1'b0;
        req_valid = 1'b0;
        chk(done === 1'b1, "R7", "done after final cycle", 32'(done), 1);
        chk(bus_cyc === 1'b0, "R7", "bus idle at done", 32'(bus_cyc), 0);
        if (!wr) chk(rdata === exp_rd, tag, "rdata", 32'(rdata), 32'(exp_rd));
        @(negedge clk);
        chk(done === 1'b0, "R7", "done one clock only", 32'(done), 0);
    endtask

    function automatic string kind_tag(input bit word, input int a);
        if (word && (a % 2 == 0)) return "R2";
        if (word) return "R5";
        if (a % 2 == 0) return "R3";
        return "R4";
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(bus_cyc === 1'b0, "R1", "bus_cyc after reset", 32'(bus_cyc), 0);
        chk(done === 1'b0, "R1", "done after reset", 32'(done), 0);
        chk(req_ready === 1'b1, "R1", "req_ready after reset", 32'(req_ready), 1);

        run_req(0, 1, 32'h01230, 16'h0, 0, 0, "R2");
        run_req(1, 1, 32'h01230, 16'hBEEF, 1, 0, "R2");
        run_req(0, 1, 32'h01230, 16'h0, 0, 0, "R2");
        run_req(1, 0, 32'h00440, 16'h0077, 0, 0, "R3");
        run_req(0, 0, 32'h00440, 16'h0, 0, 0, "R3");
        run_req(1, 0, 32'h00561, 16'hFF99, 2, 0, "R4");
        run_req(0, 0, 32'h00561, 16'h0, 0, 0, "R4");
        run_req(1, 1, 32'h00901, 16'hA1B2, 2, 0, "R5");
        run_req(0, 1, 32'h00901, 16'h0, 3, 0, "R5");
        run_req(0, 1, 32'h00900, 16'h0, 0, 0, "R2");
        run_req(1, 1, AMASK, 16'hC3D4, 1, 0, "R9");
        run_req(0, 1, AMASK, 16'h0, 0, 0, "R9");
        run_req(0, 1, 0, 16'h0, 0, 0, "R2");
        run_req(0, 1, 32'h00777, 16'h0, 0, 1, "R8");
        run_req(1, 0, 32'h00212, 16'h0055, 1, 1, "R8");

        for (int i = 0; i < 60; i++) begin
            int a = $urandom & 32'h3F;
            bit w = $urandom_range(0, 1);
            bit wr = $urandom_range(0, 1);
            run_req(wr, w, a, 16'($urandom), $urandom_range(0, 3), 0, kind_tag(w, a));
        end

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1;
            chk(1'b0, "R7", "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule